// File: doc/BRIEF.md
# Whole Vector Register Byte-Stream Loader

This block executes one kind of instruction: an unpredicated load of a complete vector register. A 32-bit instruction word arrives with a one-cycle start pulse. The block checks the word against its fixed opcode. It takes a 64-bit base from the scalar register read port, or from the stack pointer when the base field is 31. It adds a signed 9-bit immediate scaled by the vector length in bytes to that base. It then fetches the register image one byte at a time through a single-outstanding memory handshake.

Bytes are requested at consecutive ascending addresses. Each returned byte lands in the lane of the same index, with no endian reordering. Once the last byte has arrived, the whole VL-bit image is written to the destination vector register in one cycle. An instruction word that does not match raises a one-cycle undefined fault. A stack-pointer base whose low four bits are not zero raises a one-cycle alignment fault. Neither fault touches memory or the register file. The scalar read index is driven combinationally from the instruction input, and the read data is taken in the cycle the start pulse is accepted.

Top module: `vreg_bytefill_loader`

## Requirements
- R1: A word is accepted only when bits 31:22 are 1000010110 and bits 15:13 are 010. Any other word started while idle gives `fault_undef` high for exactly the next cycle, with no memory request and no register write.
- R2: The immediate is the signed 9-bit value {bits 21:16, bits 12:10}, with bits 21:16 as its upper part. The first byte address is base + imm × (VL_BITS/8), computed modulo 2^64.
- R3: Bits 9:5 of the instruction drive `xrd_idx`. A value of 31 takes the base from `sp_value` instead of `xrd_data`.
- R4: Exactly VL_BITS/8 byte requests are issued, at first address + e for e = 0, 1, … in order, with the address wrapping past 2^64−1. The byte returned for request e is placed at `vwr_data[8e+7:8e]`.
- R5: With base field 31 and `sp_value[3:0]` not zero, `fault_align` is high for exactly the next cycle, and no request or register write follows.
- R6: `mem_tagchk` is 0 on every request of a stack-pointer based load and 1 on every request of a general-register based load.
- R7: `mem_aligned` is 1 exactly when the low four bits of the first address are zero, and the same value goes out with every request of the instruction.
- R8: Only one request is in flight at a time. While `mem_req` is high and `mem_ready` is low, the request and its address hold. No new request is raised until `mem_rvalid` has returned the previous byte.
- R9: After the final byte, `vwr_en` and `done` are high together for one cycle, with `vwr_idx` equal to instruction bits 4:0.
- R10: After reset the block is idle with no request. A start pulse that arrives while `busy` is high is ignored: it causes no fault, and it does not change the destination or the addresses of the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse for `instr` |
| instr | input | 32 | Instruction word |
| xrd_idx | output | 5 | Scalar register read index |
| xrd_data | input | 64 | Scalar register read data |
| sp_value | input | 64 | Current stack pointer |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte address of the request |
| mem_tagchk | output | 1 | Tag-checked attribute of the access |
| mem_aligned | output | 1 | 16-byte alignment attribute of the first address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read byte returned |
| mem_rdata | input | 8 | Returned byte |
| vwr_en | output | 1 | Vector register write enable |
| vwr_idx | output | 5 | Vector register written |
| vwr_data | output | VL_BITS | Register image |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Load in progress |
| fault_undef | output | 1 | Undefined-opcode pulse |
| fault_align | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The load is run with an aligned general-register base and a zero immediate, which gives the plain ascending fill. It is run with the largest positive and the most negative immediates, which tell a correctly signed, correctly split and scaled offset from a mis-assembled one. It is run with a base near 2^64, which must wrap, and with stack-pointer bases that are aligned and misaligned, which separate the two base sources, the tag flag and the fault path. A memory model with varying ready stalls and response latency checks the order of the single outstanding request. A second start issued in mid-load, carrying an undefined word, has to leave the running load and the fault outputs untouched.

// File: rtl/vload_pkg.sv
package vload_pkg;

  localparam logic [9:0] OPC_HIGH = 10'b1000010110;
  localparam logic [2:0] OPC_MID  = 3'b010;
  localparam logic [4:0] SP_SEL   = 5'd31;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_AWAIT = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic              hit;
    logic [4:0]        rn;
    logic [4:0]        zt;
    logic signed [8:0] imm;
  } ld_fields_t;

  function automatic ld_fields_t split_word(input logic [31:0] w);
    ld_fields_t f;
    f.hit = (w[31:22] == OPC_HIGH) && (w[15:13] == OPC_MID);
    f.rn  = w[9:5];
    f.zt  = w[4:0];
    f.imm = {w[21:16], w[12:10]};
    return f;
  endfunction

  function automatic logic [63:0] scaled_start(input logic [63:0] base,
                                               input logic [8:0]  imm,
                                               input logic [63:0] vbytes);
    logic [63:0] ext;
    ext = {{55{imm[8]}}, imm};
    return base + (ext * vbytes);
  endfunction

endpackage

// File: rtl/vload_decode.sv
module vload_decode
  import vload_pkg::*;
#(
  parameter int VL_BITS = 128
) (
  input  logic [31:0] instr,
  input  logic [63:0] xrd_data,
  input  logic [63:0] sp_value,
  output logic [4:0]  xrd_idx,
  output logic        word_hit,
  output logic        sp_based,
  output logic        sp_misaligned,
  output logic [4:0]  dest_idx,
  output logic [63:0] first_addr,
  output logic        first_aligned
);
  localparam logic [63:0] VBYTES = 64'(VL_BITS / 8);

  ld_fields_t  fld;
  logic [63:0] base_sel;

  always_comb begin
    fld           = split_word(instr);
    xrd_idx       = fld.rn;
    word_hit      = fld.hit;
    sp_based      = (fld.rn == SP_SEL);
    sp_misaligned = (sp_value[3:0] != 4'h0);
    base_sel      = sp_based ? sp_value : xrd_data;
    dest_idx      = fld.zt;
    first_addr    = scaled_start(base_sel, fld.imm, VBYTES);
    first_aligned = (first_addr[3:0] == 4'h0);
  end
endmodule

// File: rtl/vload_byte_seq.sv
module vload_byte_seq
  import vload_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [63:0]      base_addr,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  output logic             busy,
  output logic             byte_we,
  output logic [CNT_W-1:0] byte_idx,
  output logic             finish
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mem_req = 1'b0;
    byte_we = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (launch) begin
          state_d = SQ_ISSUE;
          idx_d   = '0;
        end
      end
      SQ_ISSUE: begin
        mem_req = 1'b1;
        if (mem_ready) state_d = SQ_AWAIT;
      end
      SQ_AWAIT: begin
        if (mem_rvalid) begin
          byte_we = 1'b1;
          if (idx_q == LAST_IDX) begin
            finish  = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = SQ_ISSUE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign byte_idx = idx_q;
  assign mem_addr = base_addr + 64'(idx_q);

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R8
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  // R4
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !finish) |=> (byte_idx == $past(byte_idx) + 1'b1));
endmodule

// File: rtl/vload_assemble.sv
module vload_assemble #(
  parameter int NBYTES = 16,
  localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_we,
  input  logic [CNT_W-1:0]   byte_idx,
  input  logic [7:0]         byte_in,
  output logic [NBYTES*8-1:0] image
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lane_q <= 8'h00;
      else if (byte_we && byte_idx == CNT_W'(g))    lane_q <= byte_in;
    end
    assign image[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/vreg_bytefill_loader.sv
module vreg_bytefill_loader
  import vload_pkg::*;
#(
  parameter int VL_BITS = 128,
  localparam int NBYTES = VL_BITS / 8,
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        instr,
  output logic [4:0]         xrd_idx,
  input  logic [63:0]        xrd_data,
  input  logic [63:0]        sp_value,
  output logic               mem_req,
  output logic [63:0]        mem_addr,
  output logic               mem_tagchk,
  output logic               mem_aligned,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [7:0]         mem_rdata,
  output logic               vwr_en,
  output logic [4:0]         vwr_idx,
  output logic [VL_BITS-1:0] vwr_data,
  output logic               done,
  output logic               busy,
  output logic               fault_undef,
  output logic               fault_align
);
  logic        word_hit, sp_based, sp_misaligned, first_aligned;
  logic [4:0]  dest_idx;
  logic [63:0] first_addr;

  vload_decode #(.VL_BITS(VL_BITS)) u_dec (
    .instr(instr), .xrd_data(xrd_data), .sp_value(sp_value),
    .xrd_idx(xrd_idx), .word_hit(word_hit), .sp_based(sp_based),
    .sp_misaligned(sp_misaligned), .dest_idx(dest_idx),
    .first_addr(first_addr), .first_aligned(first_aligned)
  );

  logic accept, bad_word, bad_stack, launch;
  assign accept    = start && !busy;
  assign bad_word  = accept && !word_hit;
  assign bad_stack = accept && word_hit && sp_based && sp_misaligned;
  assign launch    = accept && word_hit && !bad_stack;

  logic [63:0] start_q;
  logic        tag_q, al_q;
  logic [4:0]  zt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      tag_q   <= 1'b0;
      al_q    <= 1'b0;
      zt_q    <= '0;
    end else if (launch) begin
      start_q <= first_addr;
      tag_q   <= !sp_based;
      al_q    <= first_aligned;
      zt_q    <= dest_idx;
    end
  end

  logic             byte_we, finish;
  logic [CNT_W-1:0] byte_idx;

  vload_byte_seq #(.NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .base_addr(start_q),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .byte_we(byte_we),
    .byte_idx(byte_idx), .finish(finish)
  );

  vload_assemble #(.NBYTES(NBYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_in(mem_rdata), .image(vwr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_undef <= 1'b0;
      fault_align <= 1'b0;
      vwr_en      <= 1'b0;
      done        <= 1'b0;
    end else begin
      fault_undef <= bad_word;
      fault_align <= bad_stack;
      vwr_en      <= finish;
      done        <= finish;
    end
  end

  assign vwr_idx     = zt_q;
  assign mem_tagchk  = tag_q;
  assign mem_aligned = al_q;

  // R1
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_undef |-> (!mem_req && !vwr_en && !busy));

  // R5
  align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align |-> (!mem_req && !busy && !fault_undef));

  // R9
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vwr_en |=> !vwr_en);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R7
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_aligned) && $stable(mem_tagchk)));
endmodule

// File: tb/vreg_bytefill_loader_tb.sv
module vreg_bytefill_loader_tb;
  localparam int VL = 128;
  localparam int NB = VL / 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start;
  logic [31:0]   instr;
  logic [4:0]    xrd_idx;
  logic [63:0]   xrd_data, sp_value;
  logic          mem_req, mem_tagchk, mem_aligned, mem_ready, mem_rvalid;
  logic [63:0]   mem_addr;
  logic [7:0]    mem_rdata;
  logic          vwr_en, done, busy, fault_undef, fault_align;
  logic [4:0]    vwr_idx;
  logic [VL-1:0] vwr_data;

  logic [63:0] xregs [32];
  assign xrd_data = xregs[xrd_idx];

  vreg_bytefill_loader #(.VL_BITS(VL)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // memory model and monitor state
  int gap = 0, lat = 0, rdy_wait = 0, pend_cnt = 0;
  bit pend = 0;
  logic [63:0] pend_addr;
  logic [63:0] exp_start;
  bit exp_tag, exp_al;
  int hs_cnt, addr_err, tag_err, al_err, flight_err, undef_cnt, algn_cnt, wr_cnt, done_cnt;
  logic [VL-1:0] got_data;
  logic [4:0] got_idx;

  function automatic logic [7:0] membyte(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ a[63:56] ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (fault_undef) undef_cnt++;
      if (fault_align) algn_cnt++;
      if (done) done_cnt++;
      if (vwr_en) begin wr_cnt++; got_data = vwr_data; got_idx = vwr_idx; end
      mem_rvalid = 1'b0;
      if (pend) begin
        if (mem_req) flight_err++;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1; mem_rdata = membyte(pend_addr); pend = 0;
        end else pend_cnt--;
      end
      if (mem_req && !pend) begin
        if (rdy_wait > 0) begin mem_ready = 1'b0; rdy_wait--; end
        else begin
          mem_ready = 1'b1;
          if (mem_addr != exp_start + 64'(hs_cnt)) addr_err++;
          if (mem_tagchk != exp_tag) tag_err++;
          if (mem_aligned != exp_al) al_err++;
          hs_cnt++; pend = 1; pend_cnt = lat; pend_addr = mem_addr; rdy_wait = gap;
        end
      end else begin
        mem_ready = 1'b0;
        if (!mem_req) rdy_wait = gap;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_img(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s image: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [8:0] imm, input logic [4:0] rn,
                                      input logic [4:0] zt);
    return {10'b1000010110, imm[8:3], 3'b010, imm[2:0], rn, zt};
  endfunction

  function automatic logic [VL-1:0] expect_img(input logic [63:0] st);
    logic [VL-1:0] r;
    for (int e = 0; e < NB; e++) r[8*e +: 8] = membyte(st + 64'(e));
    return r;
  endfunction

  task automatic clear_mon();
    hs_cnt = 0; addr_err = 0; tag_err = 0; al_err = 0; flight_err = 0;
    undef_cnt = 0; algn_cnt = 0; wr_cnt = 0; done_cnt = 0; got_data = '0; got_idx = '0;
  endtask

  task automatic fire(input logic [31:0] w);
    @(negedge clk); start = 1'b1; instr = w;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 2000 && wr_cnt == 0 && undef_cnt == 0 && algn_cnt == 0; i++)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic good_load(input string req, input logic [31:0] w, input logic [63:0] st,
                           input bit tag, input int g, input int l);
    gap = g; lat = l; exp_start = st; exp_tag = tag; exp_al = (st[3:0] == 4'h0);
    clear_mon();
    fire(w);
    settle();
    chk(hs_cnt == NB, req, "request count", 64'(hs_cnt), 64'(NB));
    chk(addr_err == 0, req, "address order errors", 64'(addr_err), 0);
    chk(tag_err == 0, "R6", "tag flag errors", 64'(tag_err), 0);
    chk(al_err == 0, "R7", "aligned attr errors", 64'(al_err), 0);
    chk(flight_err == 0, "R8", "overlapping requests", 64'(flight_err), 0);
    chk(wr_cnt == 1 && done_cnt == 1, "R9", "write/done pulses", 64'(wr_cnt), 1);
    chk(got_idx == w[4:0], "R9", "dest index", 64'(got_idx), 64'(w[4:0]));
    chk_img(req, got_data, expect_img(st));
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req, "R10", "idle after reset", {62'b0, busy, mem_req}, 0);
    chk(!vwr_en && !done && !fault_undef && !fault_align, "R10", "quiet outputs",
        {60'b0, vwr_en, done, fault_undef, fault_align}, 0);
  endtask

  task automatic t_basic();   // R4 R3
    xregs[3] = 64'h0000_0000_0000_1000;
    good_load("R4", enc(9'd0, 5'd3, 5'd7), 64'h1000, 1'b1, 0, 0);
  endtask

  task automatic t_pos_imm(); // R2 R8
    xregs[12] = 64'h0000_1234_0000_0003;
    good_load("R2", enc(9'd255, 5'd12, 5'd21), 64'h0000_1234_0000_0003 + 64'(255 * NB),
              1'b1, 1, 2);
  endtask

  task automatic t_neg_imm(); // R2
    xregs[0] = 64'h0000_0000_0002_0000;
    good_load("R2", enc(9'h100, 5'd0, 5'd31), 64'h0000_0000_0002_0000 - 64'(256 * NB),
              1'b1, 2, 0);
  endtask

  task automatic t_sp_ok();   // R3 R6
    sp_value = 64'h0000_0000_8000_0040;
    xregs[31] = 64'hDEAD_BEEF_0000_0000;
    good_load("R3", enc(9'h1FF, 5'd31, 5'd2), 64'h0000_0000_8000_0040 - 64'(NB),
              1'b0, 0, 1);
  endtask

  task automatic t_wrap();    // R4 R2
    xregs[9] = 64'hFFFF_FFFF_FFFF_FFF8;
    good_load("R4", enc(9'd0, 5'd9, 5'd4), 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 0, 0);
  endtask

  task automatic t_sp_bad();  // R5
    sp_value = 64'h0000_0000_8000_0048;
    clear_mon();
    fire(enc(9'd1, 5'd31, 5'd5));
    settle();
    chk(algn_cnt == 1, "R5", "alignment fault pulses", 64'(algn_cnt), 1);
    chk(hs_cnt == 0 && wr_cnt == 0, "R5", "no access after fault", 64'(hs_cnt + wr_cnt), 0);
    chk(undef_cnt == 0, "R5", "no undefined fault", 64'(undef_cnt), 0);
  endtask

  task automatic t_undef();   // R1
    logic [31:0] w;
    w = enc(9'd3, 5'd2, 5'd6);
    w[13] = 1'b1;
    clear_mon();
    fire(w);
    settle();
    chk(undef_cnt == 1, "R1", "undef pulse mid field", 64'(undef_cnt), 1);
    chk(hs_cnt == 0 && wr_cnt == 0, "R1", "no access mid field", 64'(hs_cnt + wr_cnt), 0);
    w = enc(9'd3, 5'd2, 5'd6);
    w[22] = 1'b1;
    clear_mon();
    fire(w);
    settle();
    chk(undef_cnt == 1, "R1", "undef pulse top field", 64'(undef_cnt), 1);
    chk(hs_cnt == 0 && wr_cnt == 0, "R1", "no access top field", 64'(hs_cnt + wr_cnt), 0);
  endtask

  task automatic t_busy_ignore(); // R10
    logic [31:0] bad;
    xregs[5] = 64'h0000_0000_0004_0000;
    xregs[6] = 64'h0000_0000_0009_0000;
    bad = 32'hFFFF_FFFF;
    gap = 1; lat = 3; exp_start = 64'h0004_0000; exp_tag = 1; exp_al = 1;
    clear_mon();
    fire(enc(9'd0, 5'd5, 5'd10));
    repeat (5) @(negedge clk);
    start = 1'b1; instr = bad;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; instr = enc(9'd0, 5'd6, 5'd11);
    @(negedge clk); start = 1'b0;
    settle();
    chk(undef_cnt == 0, "R10", "no fault while busy", 64'(undef_cnt), 0);
    chk(hs_cnt == NB && addr_err == 0, "R10", "addresses unchanged", 64'(addr_err), 0);
    chk(wr_cnt == 1 && got_idx == 5'd10, "R10", "dest unchanged", 64'(got_idx), 10);
    chk_img("R10", got_data, expect_img(64'h0004_0000));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) xregs[i] = 64'(i) * 64'h0101_0101;
    rst_n = 1'b0; start = 1'b0; instr = '0; sp_value = '0;
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    exp_start = '0; exp_tag = 0; exp_al = 0; pend_addr = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pos_imm();
    t_neg_imm();
    t_sp_ok();
    t_wrap();
    t_sp_bad();
    t_undef();
    t_busy_ignore();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule